// File: doc/BRIEF.md
# Phase-Modulating Numerically Controlled Oscillator

This block is a direct digital synthesis core. A 32-bit phase accumulator advances on every enabled clock by one of two stored frequency control words, so the output frequency is fclk × FCW / 2^32. A one-bit select input chooses the active word, and the increment follows a change of the select on the next clock. A two-bit phase modulation input adds whole quarter turns to the phase, which makes BFSK and QPSK modulation possible without reloading words. The top 13 bits of the rotated phase address a quarter-wave sine table. The table uses quadrant symmetry to produce a 12-bit offset-binary sample that can feed a D/A converter directly.

The frequency words are loaded through a serial port that runs on the core clock. A shift strobe moves one data bit into a 32-bit shift register, and a bit-order input selects MSB-first or LSB-first entry. A transfer strobe copies the shift register into whichever word the select input currently names. The accumulator can be held or cleared synchronously, so a run can start from a known phase.

Top module: `pmnco_top`

## Requirements
- R1: While reset is low, and on the first clock after reset is released, the sample output is mid-scale 0x800.
- R2: On each rising edge with the enable high and the clear low, the accumulator adds the increment register. The increment register captures the selected frequency word on every edge.
- R3: A change of the select input takes effect in the increment register on the next edge. The accumulator therefore uses the new word from the second edge onward.
- R4: If a transfer is applied at edge k, the first sample that reflects the new frequency appears after edge k+6 and not earlier.
- R5: The phase input value p (0..3) adds p × 90° to the phase. A change made before edge n is first visible at the output after edge n+3.
- R6: The offset-binary mapping is exact at the quadrant starts. With the accumulator at zero and phase input 0, 1, 2 and 3, the sample is 0x801, 0xFFF, 0x7FE and 0x000.
- R7: With the bit-order input high, each shift strobe moves the shift register toward its MSB and enters the new bit at bit 0. With the bit-order input low, the register moves toward its LSB and the new bit enters at bit 31.
- R8: With the enable low and the clear low, the accumulator holds, so a settled sample stays constant.
- R9: A clear sets the accumulator to zero on the next edge, whatever the state of the enable.
- R10: Every settled sample lies within 1 LSB of 2047.5 + 2047·sin(2π(ph+0.5)/8192), where ph is the 13-bit phase that reached the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en | input | 1 | Accumulate enable |
| acc_clr | input | 1 | Synchronous accumulator clear |
| sel_word | input | 1 | Chooses frequency word 0 or 1 (active word and transfer target) |
| phase_mod | input | 2 | Quarter-turn phase offset |
| ser_shift | input | 1 | Shift strobe for the serial word register |
| ser_dat | input | 1 | Serial data bit |
| msb_first | input | 1 | Serial bit order: 1 = MSB first, 0 = LSB first |
| xfer | input | 1 | Copies the shift register into the selected word |
| sample | output | 12 | Offset-binary sine sample |

## Verification
A wrong accumulator or increment value shows up as a drift of the phase, and the drift grows on every clock. It reaches the sample four edges after the accumulator goes wrong. Wrong serial ordering or a wrong transfer target gives a frequency far from the intended one, and this is visible six edges after the transfer. A fault in the quadrant folding or the sign inversion produces a sample off by far more than one LSB within three edges of the phase register. The exact quadrant-start values expose an off-by-one in the table or the mirror address.

// File: rtl/pmnco_pkg.sv
package pmnco_pkg;
   // quadrant of the 13-bit phase, from its two MSBs
   typedef enum logic [1:0] {
      QUAD_0   = 2'd0,
      QUAD_90  = 2'd1,
      QUAD_180 = 2'd2,
      QUAD_270 = 2'd3
   } quad_e;

   localparam int DEF_ACC_W = 32;
   localparam int DEF_PH_W  = 13;
   localparam int DEF_OUT_W = 12;
endpackage

// File: rtl/pmnco_word_load.sv
module pmnco_word_load #(
   parameter int ACC_W = 32,
   parameter int N_WORDS = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           ser_shift,
   input  logic                           ser_dat,
   input  logic                           msb_first,
   input  logic                           xfer,
   input  logic [$clog2(N_WORDS)-1:0]     sel_word,
   output logic [ACC_W-1:0]               shreg,
   output logic [N_WORDS-1:0][ACC_W-1:0]  words
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (ser_shift) begin
         if (msb_first) shreg <= {shreg[ACC_W-2:0], ser_dat};
         else           shreg <= {ser_dat, shreg[ACC_W-1:1]};
      end
   end

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)                                  words[w] <= '0;
         else if (xfer && (int'(sel_word) == w))      words[w] <= shreg;
      end
   end
endmodule

// File: rtl/pmnco_phase_path.sv
module pmnco_phase_path #(
   parameter int ACC_W = 32,
   parameter int PH_W  = 13
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      acc_en,
   input  logic                      acc_clr,
   input  logic                      sel_word,
   input  logic [1:0][ACC_W-1:0]     words,
   input  logic [1:0]                phase_mod,
   output logic [ACC_W-1:0]          incr,
   output logic [ACC_W-1:0]          acc,
   output logic [PH_W-1:0]           phase
);
   localparam int LOW_W = PH_W - 2;

   logic [PH_W-1:0] rot;
   assign rot = {phase_mod, {LOW_W{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         incr  <= '0;
         acc   <= '0;
         phase <= '0;
      end else begin
         incr <= words[sel_word];
         if (acc_clr)     acc <= '0;
         else if (acc_en) acc <= acc + incr;
         phase <= acc[ACC_W-1 -: PH_W] + rot;
      end
   end
endmodule

// File: rtl/pmnco_sine_map.sv
module pmnco_sine_map
   import pmnco_pkg::*;
#(
   parameter int PH_W  = 13,
   parameter int OUT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PH_W-1:0]   phase,
   output logic [OUT_W-1:0]  sample
);
   localparam int  QW    = PH_W - 2;
   localparam int  DEPTH = 1 << QW;
   localparam int  AMP_W = OUT_W - 1;
   localparam real FS    = real'((1 << AMP_W) - 1);
   localparam real HALF_PI = 1.5707963267948966;

   logic [AMP_W-1:0] rom [DEPTH];

   // quarter wave sampled at half-step offsets: exact mirror symmetry
   for (genvar i = 0; i < DEPTH; i++) begin : g_rom
      localparam real ANG = HALF_PI * (real'(i) + 0.5) / real'(DEPTH);
      localparam int  VAL = $rtoi(FS * $sin(ANG) + 0.5);
      assign rom[i] = AMP_W'(VAL);
   end

   quad_e          quad;
   logic [QW-1:0]  idx_fold;
   logic [QW-1:0]  idx_q;
   logic           neg_q, neg_qq;
   logic [AMP_W-1:0] amp_q;

   assign quad = quad_e'(phase[PH_W-1 -: 2]);

   always_comb begin
      case (quad)
         QUAD_90, QUAD_270: idx_fold = ~phase[QW-1:0];
         default:           idx_fold =  phase[QW-1:0];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         neg_q  <= 1'b0;
         amp_q  <= '0;
         neg_qq <= 1'b0;
         sample <= OUT_W'(1) << AMP_W;
      end else begin
         idx_q  <= idx_fold;
         neg_q  <= (quad == QUAD_180) || (quad == QUAD_270);
         amp_q  <= rom[idx_q];
         neg_qq <= neg_q;
         sample <= neg_qq ? ~{1'b1, amp_q} : {1'b1, amp_q};
      end
   end
endmodule

// File: rtl/pmnco_top.sv
module pmnco_top
   import pmnco_pkg::*;
#(
   parameter int ACC_W = DEF_ACC_W,
   parameter int PH_W  = DEF_PH_W,
   parameter int OUT_W = DEF_OUT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  logic             acc_clr,
   input  logic             sel_word,
   input  logic [1:0]       phase_mod,
   input  logic             ser_shift,
   input  logic             ser_dat,
   input  logic             msb_first,
   input  logic             xfer,
   output logic [OUT_W-1:0] sample
);
   if (PH_W < 4 || PH_W > ACC_W) begin : g_bad_ph
      $error("pmnco_top: PH_W must lie in 4..ACC_W");
   end
   if (PH_W - 2 > 14) begin : g_bad_rom
      $error("pmnco_top: quarter table would exceed 16K entries");
   end
   if (OUT_W < 4) begin : g_bad_out
      $error("pmnco_top: OUT_W must be at least 4");
   end

   logic [ACC_W-1:0]            shreg_w;
   logic [1:0][ACC_W-1:0]       words_w;
   logic [ACC_W-1:0]            incr_w;
   logic [ACC_W-1:0]            acc_w;
   logic [PH_W-1:0]             phase_w;

   pmnco_word_load #(.ACC_W(ACC_W), .N_WORDS(2)) u_load (
      .clk(clk), .rst_n(rst_n), .ser_shift(ser_shift), .ser_dat(ser_dat),
      .msb_first(msb_first), .xfer(xfer), .sel_word(sel_word),
      .shreg(shreg_w), .words(words_w)
   );

   pmnco_phase_path #(.ACC_W(ACC_W), .PH_W(PH_W)) u_path (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_clr(acc_clr),
      .sel_word(sel_word), .words(words_w), .phase_mod(phase_mod),
      .incr(incr_w), .acc(acc_w), .phase(phase_w)
   );

   pmnco_sine_map #(.PH_W(PH_W), .OUT_W(OUT_W)) u_map (
      .clk(clk), .rst_n(rst_n), .phase(phase_w), .sample(sample)
   );
endmodule

// File: rtl/pmnco_chk.sv
module pmnco_chk #(
   parameter int ACC_W = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  acc_en,
   input logic                  acc_clr,
   input logic                  sel_word,
   input logic                  ser_shift,
   input logic                  ser_dat,
   input logic                  msb_first,
   input logic [1:0][ACC_W-1:0] words,
   input logic [ACC_W-1:0]      shreg,
   input logic [ACC_W-1:0]      incr,
   input logic [ACC_W-1:0]      acc
);
   // R2
   acc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_clr) |=> (acc == ACC_W'($past(acc) + $past(incr))));

   // R3
   incr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (incr == $past(words[sel_word])));

   // R7
   shift_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_shift && msb_first) |=>
         (shreg[0] == $past(ser_dat)) && (shreg[ACC_W-1:1] == $past(shreg[ACC_W-2:0])));

   // R7
   shift_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_shift && !msb_first) |=>
         (shreg[ACC_W-1] == $past(ser_dat)) && (shreg[ACC_W-2:0] == $past(shreg[ACC_W-1:1])));

   // R8
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_en && !acc_clr) |=> $stable(acc));

   // R9
   acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_clr |=> (acc == '0));
endmodule

bind pmnco_top pmnco_chk #(.ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_clr(acc_clr),
   .sel_word(sel_word), .ser_shift(ser_shift), .ser_dat(ser_dat),
   .msb_first(msb_first), .words(words_w), .shreg(shreg_w),
   .incr(incr_w), .acc(acc_w)
);

// File: tb/pmnco_top_test.sv
`timescale 1ns/1ps
module pmnco_top_test;
   localparam int  AW = 32;
   localparam int  PW = 13;
   localparam int  OW = 12;
   localparam real PI = 3.141592653589793;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, acc_en, acc_clr, sel_word, ser_shift, ser_dat, msb_first, xfer;
   logic [1:0]    phase_mod;
   logic [OW-1:0] sample;

   pmnco_top uut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_clr(acc_clr),
      .sel_word(sel_word), .phase_mod(phase_mod), .ser_shift(ser_shift),
      .ser_dat(ser_dat), .msb_first(msb_first), .xfer(xfer), .sample(sample)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   string cur_req = "R10";

   // reference state built from the requirements
   logic [AW-1:0] m_sh, m_w0, m_w1, m_incr, m_acc;
   logic [PW-1:0] m_p, m_d1, m_d2, m_d3;
   int            since_rst = 0;

   function automatic real ref_of(logic [PW-1:0] p);
      return 2047.5 + 2047.0 * $sin(2.0 * PI * (real'(p) + 0.5) / 8192.0);
   endfunction

   task automatic chk_near(logic [PW-1:0] p, string req);
      real r, d;
      r = ref_of(p);
      d = real'(sample) - r;
      n_vec++;
      if (d > 1.0001 || d < -1.0001) begin
         n_bad++;
         $display("FAIL %s: sample=%0d expected=%0.2f (phase %0h)", req, sample, r, p);
      end
   endtask

   task automatic chk_eq(logic [OW-1:0] exp, string req);
      n_vec++;
      if (sample !== exp) begin
         n_bad++;
         $display("FAIL %s: sample=%03h expected=%03h", req, sample, exp);
      end
   endtask

   task automatic step();
      logic [AW-1:0] n_sh, n_w0, n_w1, n_incr, n_acc;
      logic [PW-1:0] n_p;
      n_sh = m_sh; n_w0 = m_w0; n_w1 = m_w1;
      if (ser_shift) n_sh = msb_first ? {m_sh[AW-2:0], ser_dat} : {ser_dat, m_sh[AW-1:1]};
      if (xfer) begin
         if (sel_word) n_w1 = m_sh; else n_w0 = m_sh;
      end
      n_incr = sel_word ? m_w1 : m_w0;
      n_acc  = acc_clr ? '0 : (acc_en ? m_acc + m_incr : m_acc);
      n_p    = m_acc[AW-1 -: PW] + {phase_mod, 11'b0};
      @(posedge clk); #1;
      if (!rst_n) begin
         m_sh = '0; m_w0 = '0; m_w1 = '0; m_incr = '0; m_acc = '0;
         m_p = '0; m_d1 = '0; m_d2 = '0; m_d3 = '0; since_rst = 0;
      end else begin
         m_sh = n_sh; m_w0 = n_w0; m_w1 = n_w1; m_incr = n_incr; m_acc = n_acc;
         m_d3 = m_d2; m_d2 = m_d1; m_d1 = m_p; m_p = n_p;
         since_rst++;
         if (since_rst >= 3) chk_near(m_d3, cur_req);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; acc_en = 1'b1; acc_clr = 1'b0; sel_word = 1'b0; phase_mod = 2'd0;
      ser_shift = 1'b0; ser_dat = 1'b0; msb_first = 1'b1; xfer = 1'b0;
      step(); step();
      rst_n = 1'b1;
   endtask

   task automatic load_word(logic [AW-1:0] val, logic msb);
      msb_first = msb;
      for (int i = 0; i < AW; i++) begin
         ser_shift = 1'b1;
         ser_dat   = msb ? val[AW-1-i] : val[i];
         step();
      end
      ser_shift = 1'b0;
      xfer = 1'b1;
      step();
      xfer = 1'b0;
   endtask

   task automatic t_reset();
      cur_req = "R1";
      do_reset();
      chk_eq(12'h800, "R1 during reset");
      step();
      chk_eq(12'h800, "R1 first edge after reset");
      repeat (4) step();
   endtask

   task automatic t_quadrants();
      logic [OW-1:0] qv [4];
      logic [OW-1:0] prev;
      qv[0] = 12'h801; qv[1] = 12'hFFF; qv[2] = 12'h7FE; qv[3] = 12'h000;
      cur_req = "R6";
      do_reset();
      repeat (5) step();
      chk_eq(12'h801, "R6 quadrant 0");
      prev = 12'h801;
      for (int k = 1; k <= 4; k++) begin
         phase_mod = 2'(k);
         repeat (3) step();
         chk_eq(prev, "R5 offset not yet visible");
         step();
         chk_eq(qv[k % 4], "R6 quadrant start value");
         prev = qv[k % 4];
      end
   endtask

   task automatic t_latency();
      cur_req = "R4";
      do_reset();
      repeat (4) step();
      load_word(32'h2000_0000, 1'b1);
      for (int s = 1; s <= 5; s++) begin
         step();
         chk_eq(12'h801, "R4 old frequency still at output");
      end
      step();
      chk_near(13'h400, "R4 new frequency after six edges");
      repeat (10) step();
   endtask

   task automatic t_select();
      cur_req = "R3";
      do_reset();
      load_word(32'h2000_0000, 1'b1);
      sel_word = 1'b1;
      load_word(32'h0130_0000, 1'b1);
      acc_clr = 1'b1; step(); acc_clr = 1'b0;
      repeat (6) step();
      for (int k = 0; k < 6; k++) begin
         sel_word = ~sel_word;
         repeat (k + 1) step();
      end
      phase_mod = 2'd3;
      repeat (8) step();
   endtask

   task automatic t_serial();
      cur_req = "R7";
      do_reset();
      load_word(32'h2000_0001, 1'b0);
      acc_clr = 1'b1; step(); acc_clr = 1'b0;
      repeat (12) step();
      sel_word = 1'b1;
      load_word(32'h0C40_0000, 1'b1);
      repeat (12) step();
      sel_word = 1'b0;
      load_word(32'h0000_8C01, 1'b0);
      repeat (12) step();
   endtask

   task automatic t_hold_clear();
      logic [OW-1:0] held;
      cur_req = "R8";
      do_reset();
      load_word(32'h0733_0000, 1'b1);
      repeat (7) step();
      acc_en = 1'b0;
      repeat (5) step();
      held = sample;
      repeat (6) step();
      chk_eq(held, "R8 sample holds with enable low");
      cur_req = "R9";
      acc_en = 1'b1; acc_clr = 1'b1;
      step();
      acc_clr = 1'b0; acc_en = 1'b0;
      repeat (5) step();
      chk_eq(12'h801, "R9 clear returns phase to zero");
      acc_en = 1'b1;
      repeat (10) step();
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_quadrants();
      t_latency();
      t_select();
      t_serial();
      t_hold_clear();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule